// File: doc/BRIEF.md
# UART Modem Line Control and Status Unit

This block keeps the modem control register and the modem status register of a single UART channel. The control register drives the active-low data-terminal-ready, request-to-send and general-purpose output pins, and the enable of the channel's tri-state interrupt pin. The status register reports the four active-low modem inputs (clear-to-send, data-set-ready, ring indicator, carrier detect) as active-high levels. Each of those inputs first passes through a two-flop synchroniser. The status register also holds sticky change flags, and reading the register clears them.

A host reaches both registers through a plain register port. It has a one-bit select (0 = control, 1 = status), a write strobe, a read strobe and a combinational read-data bus. Writing a 1 to control bit 4 selects internal loopback. In loopback the low control bits stand in for the modem inputs, the output pins are parked inactive, and the `loop_mode` output tells the serial section to route TX to RX internally. Control bits 7..5 are stored, and can be written only while `ext_wr_en` is high. The register port carries single register accesses and has no streaming data. It therefore uses plain strobes with no valid/ready back-pressure: every strobe takes effect in the cycle it is high.

Top module: `modem_ctl_unit`

## Requirements
- R1: After reset the control register reads 0x00, all change flags are 0, `dtr_n`, `rts_n` and `op_n` are 1, and `irq_oe` is 0.
- R2: Outside loopback, `dtr_n` equals the inverse of control bit 0, and `rts_n` equals the inverse of control bit 1 when auto-RTS is off.
- R3: Outside loopback with `autorts_en`=1, `rts_n` equals the inverse of `flow_rts_req`, whatever control bit 1 holds.
- R4: Outside loopback, control bit 3 = 1 drives `op_n` low and `irq_oe` high. Control bit 3 = 0 drives `op_n` high and `irq_oe` low. `irq_oe` follows control bit 3 in loopback too.
- R5: A control write updates bits 4..0 always. It updates bits 7..5 only when `ext_wr_en`=1; otherwise those bits keep their old value.
- R6: Outside loopback, status bits 7,6,5,4 equal the inverted synchronised `cd_n`, `ri_n`, `dsr_n`, `cts_n`. A pin change is visible no later than the third rising edge after it.
- R7: With control bit 4 = 1, `loop_mode` is 1. Status bits 7,6,5,4 then equal control bits 3,2,0,1 respectively, external pin levels have no effect, and `dtr_n`, `rts_n`, `op_n` are held at 1.
- R8: Status bits 0, 1 and 3 are set by any change of the clear-to-send, data-set-ready and carrier-detect sources respectively (status bits 4, 5, 7). They stay set until a status read clears them.
- R9: Status bit 2 is set only when the ring source goes from active to inactive (status bit 6 falls 1 to 0, i.e. `ri_n` rises), and never on the opposite edge. A status read clears it.
- R10: A source change in the same cycle as a status read leaves that change's flag set after the read.
- R11: Entering or leaving loopback sets the change flags of every status bit 7..4 whose value changes because of the switch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Register select: 0 control, 1 status |
| wr_en | input | 1 | Write strobe (control register only) |
| rd_en | input | 1 | Read strobe; with reg_sel=1 clears change flags |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data of the selected register |
| ext_wr_en | input | 1 | Write enable for control bits 7..5 |
| autorts_en | input | 1 | Auto-RTS flow control enable |
| flow_rts_req | input | 1 | Flow-control RTS request, 1 = assert |
| cts_n | input | 1 | Clear-to-send, active low, asynchronous |
| dsr_n | input | 1 | Data-set-ready, active low, asynchronous |
| ri_n | input | 1 | Ring indicator, active low, asynchronous |
| cd_n | input | 1 | Carrier detect, active low, asynchronous |
| dtr_n | output | 1 | Data-terminal-ready, active low |
| rts_n | output | 1 | Request-to-send, active low |
| op_n | output | 1 | General-purpose output, active low |
| irq_oe | output | 1 | Output enable of the tri-state interrupt pin |
| loop_mode | output | 1 | Internal loopback selected |

## Verification
Normal mode is tried with all sixteen levels of the four modem pins, stepped in a scrambled order. Each step changes a different set of lines, which separates the symmetric change flags from the ring flag that fires on one edge only. Loopback runs all sixteen values of the low control nibble while the external pins are held active. This exposes any wrong bit remapping and any leakage from the pins. Writes with and without the upper-bit enable, a mode switch in each direction, auto-RTS against the control bit, and a read that lands in the same cycle as a change cover the remaining corners.

// File: rtl/mcu_pkg.sv
package mcu_pkg;
  localparam int REG_W = 8;
  localparam int N_LINES = 4;

  typedef enum logic {
    SEL_CTRL = 1'b0,
    SEL_STAT = 1'b1
  } reg_sel_e;

  // control register bit positions
  localparam int C_DTR  = 0;
  localparam int C_RTS  = 1;
  localparam int C_AUX  = 2;
  localparam int C_IRQ  = 3;
  localparam int C_LOOP = 4;
  localparam int C_LOCK_LO = 5;

  // modem line index inside the source vector (status bit = index + 4)
  localparam int L_CTS = 0;
  localparam int L_DSR = 1;
  localparam int L_RI  = 2;
  localparam int L_CD  = 3;
endpackage

// File: rtl/mcu_sync.sv
module mcu_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH = 4,
  parameter logic RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= {WIDTH{RST_VAL}};
    else        chain[0] <= d_async;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= {WIDTH{RST_VAL}};
      else        chain[s] <= chain[s-1];
    end
  end

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/mcu_ctrl_reg.sv
module mcu_ctrl_reg
  import mcu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  input  logic             ext_wr_en,
  input  logic             autorts_en,
  input  logic             flow_rts_req,
  output logic [REG_W-1:0] ctrl,
  output logic             dtr_n,
  output logic             rts_n,
  output logic             op_n,
  output logic             irq_oe
);
  logic [REG_W-1:0] ctrl_nxt;
  logic             loop;

  always_comb begin
    ctrl_nxt = ctrl;
    if (wr) begin
      ctrl_nxt[C_LOCK_LO-1:0] = wdata[C_LOCK_LO-1:0];
      if (ext_wr_en) ctrl_nxt[REG_W-1:C_LOCK_LO] = wdata[REG_W-1:C_LOCK_LO];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl <= '0;
    else        ctrl <= ctrl_nxt;
  end

  assign loop   = ctrl[C_LOOP];
  assign dtr_n  = loop | ~ctrl[C_DTR];
  assign rts_n  = loop | (autorts_en ? ~flow_rts_req : ~ctrl[C_RTS]);
  assign op_n   = loop | ~ctrl[C_IRQ];
  assign irq_oe = ctrl[C_IRQ];

  p_upper_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !ext_wr_en) |=> (ctrl[REG_W-1:C_LOCK_LO] == $past(ctrl[REG_W-1:C_LOCK_LO])));

  p_lower_written_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (ctrl[C_LOCK_LO-1:0] == $past(wdata[C_LOCK_LO-1:0])));
endmodule

// File: rtl/mcu_status.sv
module mcu_status
  import mcu_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] src,
  input  logic               rd_clr,
  output logic [REG_W-1:0]   status
);
  logic [N_LINES-1:0] src_q;
  logic [N_LINES-1:0] ev;
  logic [N_LINES-1:0] delta;

  always_comb begin
    ev        = src ^ src_q;
    ev[L_RI]  = src_q[L_RI] & ~src[L_RI];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
      delta <= '0;
    end else begin
      src_q <= src;
      delta <= (rd_clr ? '0 : delta) | ev;
    end
  end

  assign status = {src, delta};

  p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_clr |=> ((delta & ~$past(ev)) == '0));

  p_ri_rise_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(delta[L_RI]) |-> !src_q[L_RI]);

  p_event_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ev != '0) |=> ((delta & $past(ev)) == $past(ev)));
endmodule

// File: rtl/modem_ctl_unit.sv
module modem_ctl_unit
  import mcu_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_sel,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       ext_wr_en,
  input  logic       autorts_en,
  input  logic       flow_rts_req,
  input  logic       cts_n,
  input  logic       dsr_n,
  input  logic       ri_n,
  input  logic       cd_n,
  output logic       dtr_n,
  output logic       rts_n,
  output logic       op_n,
  output logic       irq_oe,
  output logic       loop_mode
);
  logic [REG_W-1:0]   ctrl;
  logic [REG_W-1:0]   status;
  logic [N_LINES-1:0] pins_n;
  logic [N_LINES-1:0] pins_s;
  logic [N_LINES-1:0] loop_src;
  logic [N_LINES-1:0] src;
  logic               wr_ctrl;
  logic               rd_clr;

  assign pins_n = {cd_n, ri_n, dsr_n, cts_n};

  mcu_sync #(.STAGES(SYNC_STAGES), .WIDTH(N_LINES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(pins_n), .q_sync(pins_s)
  );

  assign wr_ctrl = wr_en && (reg_sel_e'(reg_sel) == SEL_CTRL);
  assign rd_clr  = rd_en && (reg_sel_e'(reg_sel) == SEL_STAT);

  mcu_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr(wr_ctrl), .wdata(wr_data),
    .ext_wr_en(ext_wr_en), .autorts_en(autorts_en), .flow_rts_req(flow_rts_req),
    .ctrl(ctrl), .dtr_n(dtr_n), .rts_n(rts_n), .op_n(op_n), .irq_oe(irq_oe)
  );

  assign loop_mode = ctrl[C_LOOP];

  always_comb begin
    loop_src        = '0;
    loop_src[L_CTS] = ctrl[C_RTS];
    loop_src[L_DSR] = ctrl[C_DTR];
    loop_src[L_RI]  = ctrl[C_AUX];
    loop_src[L_CD]  = ctrl[C_IRQ];
  end

  assign src = loop_mode ? loop_src : ~pins_s;

  mcu_status u_status (
    .clk(clk), .rst_n(rst_n), .src(src), .rd_clr(rd_clr), .status(status)
  );

  assign rd_data = (reg_sel_e'(reg_sel) == SEL_STAT) ? status : ctrl;

  p_loop_pins_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    loop_mode |-> (dtr_n && rts_n && op_n));

  p_irq_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!loop_mode) |-> (op_n == !irq_oe));
endmodule

// File: tb/modem_ctl_unit_bench.sv
module modem_ctl_unit_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_sel = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic ext_wr_en = 1'b0, autorts_en = 1'b0, flow_rts_req = 1'b0;
  logic cts_n = 1'b1, dsr_n = 1'b1, ri_n = 1'b1, cd_n = 1'b1;
  logic dtr_n, rts_n, op_n, irq_oe, loop_mode;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  modem_ctl_unit u_modem_ctl_unit (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en), .rd_en(rd_en),
    .wr_data(wr_data), .rd_data(rd_data), .ext_wr_en(ext_wr_en),
    .autorts_en(autorts_en), .flow_rts_req(flow_rts_req),
    .cts_n(cts_n), .dsr_n(dsr_n), .ri_n(ri_n), .cd_n(cd_n),
    .dtr_n(dtr_n), .rts_n(rts_n), .op_n(op_n), .irq_oe(irq_oe), .loop_mode(loop_mode)
  );

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic write_ctrl(input logic [7:0] d, input bit ext);
    reg_sel = 1'b0; wr_en = 1'b1; wr_data = d; ext_wr_en = ext;
    @(negedge clk);
    wr_en = 1'b0; ext_wr_en = 1'b0;
  endtask

  task automatic read_status(output logic [7:0] v);
    reg_sel = 1'b1; rd_en = 1'b1;
    #1 v = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic read_ctrl(output logic [7:0] v);
    reg_sel = 1'b0;
    #1 v = rd_data;
  endtask

  task automatic set_pins(input logic [3:0] p);
    {cd_n, ri_n, dsr_n, cts_n} = p;
  endtask

  function automatic logic [3:0] deltas(input logic [3:0] prv, input logic [3:0] nxt);
    logic [3:0] c;
    c = prv ^ nxt;
    return {c[3], prv[2] & ~nxt[2], c[1], c[0]};
  endfunction

  initial begin
    logic [7:0] v;
    logic [3:0] prev_src, new_src, p;
    wait_cyc(3);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk({dtr_n, rts_n, op_n, irq_oe} == 4'b1110, "R1 pins", {4'b0, dtr_n, rts_n, op_n, irq_oe}, 8'h0e);
    read_ctrl(v);
    chk(v == 8'h00, "R1 ctrl", v, 8'h00);
    read_status(v);
    chk(v == 8'h00, "R1 status", v, 8'h00);

    // R6 R8 R9: normal-mode sweep over all pin levels
    prev_src = 4'h0;
    for (int i = 1; i <= 16; i++) begin
      p = 4'((i * 7) % 16);
      set_pins(p);
      new_src = ~p;
      wait_cyc(4);
      read_status(v);
      chk(v[7:4] == new_src, "R6 level", v, {new_src, 4'h0});
      chk(v[3:0] == deltas(prev_src, new_src), "R8/R9 delta", v, {4'h0, deltas(prev_src, new_src)});
      read_status(v);
      chk(v[3:0] == 4'h0, "R8 clear on read", v, {new_src, 4'h0});
      prev_src = new_src;
    end

    // R11: entering loopback with ctrl nibble 0
    write_ctrl(8'h10, 1'b0);
    wait_cyc(2);
    read_status(v);
    chk(v == {4'h0, deltas(prev_src, 4'h0)}, "R11 enter", v, {4'h0, deltas(prev_src, 4'h0)});
    prev_src = 4'h0;

    // R7: loopback sweep, external pins all active (must not matter)
    set_pins(4'h0);
    for (int k = 0; k < 16; k++) begin
      logic [3:0] n;
      n = 4'((k * 5 + 3) % 16);
      write_ctrl({4'h1, n}, 1'b0);
      new_src = {n[3], n[2], n[0], n[1]};
      wait_cyc(2);
      chk({loop_mode, dtr_n, rts_n, op_n} == 4'b1111, "R7 pins", {4'h0, loop_mode, dtr_n, rts_n, op_n}, 8'h0f);
      chk(irq_oe == n[3], "R4 irq in loop", {7'h0, irq_oe}, {7'h0, n[3]});
      read_status(v);
      chk(v == {new_src, deltas(prev_src, new_src)}, "R7 status", v, {new_src, deltas(prev_src, new_src)});
      prev_src = new_src;
    end

    // R10: change lands in the same cycle as a status read
    write_ctrl(8'h10, 1'b0);
    wait_cyc(2);
    read_status(v);
    reg_sel = 1'b0; wr_en = 1'b1; wr_data = 8'h11;
    @(negedge clk);
    wr_en = 1'b0; reg_sel = 1'b1; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    read_status(v);
    chk(v == 8'h22, "R10 kept", v, 8'h22);

    // R11: leaving loopback, pins all active -> all sources go to 1
    write_ctrl(8'h00, 1'b0);
    wait_cyc(4);
    read_status(v);
    chk(v == {4'hf, deltas(4'b0010, 4'hf)}, "R11 leave", v, {4'hf, deltas(4'b0010, 4'hf)});

    // R2 R4: output pins over all low nibbles in normal mode
    for (int k = 0; k < 16; k++) begin
      write_ctrl(8'(k), 1'b0);
      #1;
      chk({dtr_n, rts_n, op_n, irq_oe} == {~k[0], ~k[1], ~k[3], k[3]}, "R2/R4 pins",
          {4'h0, dtr_n, rts_n, op_n, irq_oe}, {4'h0, ~k[0], ~k[1], ~k[3], k[3]});
    end

    // R3: auto-RTS overrides control bit 1
    autorts_en = 1'b1;
    write_ctrl(8'h02, 1'b0);
    flow_rts_req = 1'b0; #1;
    chk(rts_n == 1'b1, "R3 auto off", {7'h0, rts_n}, 8'h01);
    write_ctrl(8'h00, 1'b0);
    flow_rts_req = 1'b1; #1;
    chk(rts_n == 1'b0, "R3 auto on", {7'h0, rts_n}, 8'h00);
    autorts_en = 1'b0; flow_rts_req = 1'b0;

    // R5: gated upper bits
    write_ctrl(8'he0, 1'b0);
    read_ctrl(v);
    chk(v == 8'h00, "R5 locked", v, 8'h00);
    write_ctrl(8'he0, 1'b1);
    read_ctrl(v);
    chk(v == 8'he0, "R5 open", v, 8'he0);
    write_ctrl(8'h05, 1'b0);
    read_ctrl(v);
    chk(v == 8'he5, "R5 kept", v, 8'he5);
    write_ctrl(8'h00, 1'b1);
    read_ctrl(v);
    chk(v == 8'h00, "R5 cleared", v, 8'h00);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%02h expected=%02h", 8'h00, 8'h01);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule